// File: doc/BRIEF.md
# Programmable Digital Input Glitch Filter Bank

This block cleans up a bank of 8-bit digital input ports before they reach the data read path and any downstream edge logic. Each input line is first brought into the clock domain through a two-stage synchronizer. A line that has filtering switched on only changes its output once the synchronized input has held a new level, without interruption, for a programmable number of 200 ns ticks. Shorter pulses and bounces are absorbed. A line with filtering switched off passes its synchronized level straight through.

A single 20-bit interval, counted in 200 ns ticks, is shared by every filtered line on every port. Each port has its own enable byte with one bit per line. Both are written over a simple byte-wide write bus. A free-running prescaler, sized from a clock-frequency parameter, produces the 200 ns tick.

Each line is a three-state machine. `LN_BYPASS` copies the synchronized level every cycle. `LN_HOLD` keeps the output while the input agrees with it. `LN_QUALIFY` counts ticks while the input disagrees.

The transitions are:
- any state goes to `LN_BYPASS` when the line's enable bit is clear or the interval is 0;
- `LN_BYPASS` or `LN_HOLD` goes to `LN_HOLD` while input and output agree;
- `LN_BYPASS` or `LN_HOLD` goes to `LN_QUALIFY` on a disagreement that does not complete at once;
- `LN_QUALIFY` returns to `LN_HOLD` on a bounce back to the held level;
- `LN_QUALIFY` returns to `LN_HOLD` with the output updated on the tick that reaches the interval;
- `LN_QUALIFY` otherwise stays in `LN_QUALIFY`.

Top module: `gf_bank`

## Requirements
- R1: After reset every enable bit is 0, the interval is 0 and every output bit is 0.
- R2: A line whose enable bit is clear drives its output with its raw input delayed by exactly three rising clock edges.
- R3: While the interval is 0, every line passes its input through with the three-edge delay of R2, even when its enable bit is set.
- R4: The tick is a one-cycle strobe that recurs every TICK_CYC = CLK_HZ·TICK_NS/1e9 cycles (50 at the default 250 MHz). The first strobe is seen at the TICK_CYC-th rising edge after reset is released, so a filtered output can change only on such an edge.
- R5: For a filtered line with interval N > 0, a count advances on every tick edge at which the synchronized input differs from the output. The output takes the new level at the tick edge where the count reaches N.
- R6: If the synchronized input of a filtered line returns to the output level before the count reaches N, the count restarts from zero and the output does not change.
- R7: The interval is written a byte at a time: address 0x08 holds bits 7:0, 0x09 holds bits 15:8 and 0x0A holds bits 19:16. A byte above 0x0F written to 0x0A saturates the whole interval to 0xFFFFF.
- R8: The enable byte of port p is at address 0x44 + 0x10·p, and its bit b controls line 8·p + b of `raw_in`/`lines_out`. Writes to any address other than those in R7 and R8 change nothing.
- R9: A new interval or enable value is used from the next clock edge on. A count already at or above a lowered interval completes on the next tick, and clearing an enable bit makes the line follow its input on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one byte per cycle |
| wr_addr | input | 8 | Register byte address |
| wr_data | input | 8 | Register write data |
| raw_in | input | 8·NUM_PORTS | Unsynchronized digital inputs, port p on bits 8p+7:8p |
| lines_out | output | 8·NUM_PORTS | Conditioned lines toward the read path and edge logic |

## Verification
The embedded properties assume that `raw_in` may change at any time, but that `wr_en`, `wr_addr` and `wr_data` are stable around each rising edge and carry one byte per strobe. The stimulus changes every input at the falling edge and issues each write as a single-cycle strobe. Glitch runs are timed against the 50-cycle tick so that bounces last both shorter and longer than one tick. The enable and interval settings are changed while counts are in progress, which exercises the live-reconfiguration behaviour.

// File: rtl/gf_pkg.sv
package gf_pkg;
    localparam int unsigned GF_PORT_W   = 8;
    localparam int unsigned GF_IVL_W    = 20;
    localparam int unsigned GF_TOP_BITS = GF_IVL_W - 16;

    localparam logic [7:0] ADDR_IVL_LO  = 8'h08;
    localparam logic [7:0] ADDR_IVL_MID = 8'h09;
    localparam logic [7:0] ADDR_IVL_TOP = 8'h0A;
    localparam logic [7:0] ADDR_EN_BASE = 8'h44;
    localparam logic [7:0] ADDR_EN_STEP = 8'h10;

    typedef enum logic [1:0] {
        LN_BYPASS  = 2'd0,
        LN_HOLD    = 2'd1,
        LN_QUALIFY = 2'd2
    } ln_state_e;
endpackage

// File: rtl/gf_tick_gen.sv
module gf_tick_gen #(
    parameter int unsigned TICK_CYC = 50
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int unsigned CW = (TICK_CYC > 1) ? $clog2(TICK_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_CYC - 1);

    logic [CW-1:0] pc_q;

    assign tick = (pc_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q <= '0;
        end else if (tick) begin
            pc_q <= '0;
        end else begin
            pc_q <= pc_q + CW'(1);
        end
    end

    generate
        if (TICK_CYC > 1) begin : g_pulse_chk
            // R4
            tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick)
                else $error("tick strobe lasted more than one cycle");
        end
    endgenerate
endmodule

// File: rtl/gf_cfg_regs.sv
module gf_cfg_regs
    import gf_pkg::*;
#(
    parameter int unsigned NUM_PORTS = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [7:0]                        wr_addr,
    input  logic [7:0]                        wr_data,
    output logic [GF_IVL_W-1:0]               ivl,
    output logic [NUM_PORTS*GF_PORT_W-1:0]    en
);
    localparam logic [7:0] TOP_MAX = 8'((1 << GF_TOP_BITS) - 1);

    logic [GF_IVL_W-1:0] ivl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ivl_q <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                ADDR_IVL_LO:  ivl_q[7:0]  <= wr_data;
                ADDR_IVL_MID: ivl_q[15:8] <= wr_data;
                ADDR_IVL_TOP: begin
                    if (wr_data > TOP_MAX) begin
                        ivl_q <= '1;
                    end else begin
                        ivl_q[GF_IVL_W-1:16] <= wr_data[GF_TOP_BITS-1:0];
                    end
                end
                default: ivl_q <= ivl_q;
            endcase
        end
    end

    assign ivl = ivl_q;

    // R7
    ivl_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_IVL_TOP && wr_data > TOP_MAX) |=> (ivl == '1))
        else $error("oversized top byte did not saturate the interval");

    genvar p;
    generate
        for (p = 0; p < NUM_PORTS; p++) begin : g_port_en
            localparam logic [7:0] EN_ADDR = 8'(ADDR_EN_BASE + ADDR_EN_STEP * p);
            logic [GF_PORT_W-1:0] en_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    en_q <= '0;
                end else if (wr_en && wr_addr == EN_ADDR) begin
                    en_q <= wr_data;
                end
            end

            assign en[p*GF_PORT_W +: GF_PORT_W] = en_q;

            // R8
            en_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && wr_addr == EN_ADDR) |=> (en[p*GF_PORT_W +: GF_PORT_W] == $past(wr_data)))
                else $error("enable byte write was not captured");

            // R8
            en_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !(wr_en && wr_addr == EN_ADDR) |=> $stable(en[p*GF_PORT_W +: GF_PORT_W]))
                else $error("enable byte changed without a matching write");
        end
    endgenerate
endmodule

// File: rtl/gf_line.sv
module gf_line
    import gf_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                raw,
    input  logic                en,
    input  logic [GF_IVL_W-1:0] ivl,
    input  logic                tick,
    output logic                line_out
);
    logic                sync1_q;
    logic                sync_q;
    logic                out_q;
    logic                out_d;
    logic [GF_IVL_W-1:0] cnt_q;
    logic [GF_IVL_W-1:0] cnt_d;
    ln_state_e           state_q;
    ln_state_e           state_d;

    logic                byp;
    logic [GF_IVL_W:0]   cnt_inc;
    logic                reach;

    assign byp     = !en || (ivl == '0);
    assign cnt_inc = {1'b0, cnt_q} + {{GF_IVL_W{1'b0}}, 1'b1};
    assign reach   = (cnt_inc >= {1'b0, ivl});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync1_q <= 1'b0;
            sync_q  <= 1'b0;
            state_q <= LN_BYPASS;
            out_q   <= 1'b0;
            cnt_q   <= '0;
        end else begin
            sync1_q <= raw;
            sync_q  <= sync1_q;
            state_q <= state_d;
            out_q   <= out_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        out_d   = out_q;
        cnt_d   = cnt_q;
        if (byp) begin
            state_d = LN_BYPASS;
            out_d   = sync_q;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                LN_BYPASS, LN_HOLD: begin
                    cnt_d = '0;
                    if (sync_q == out_q) begin
                        state_d = LN_HOLD;
                    end else if (tick && reach) begin
                        state_d = LN_HOLD;
                        out_d   = sync_q;
                    end else begin
                        state_d = LN_QUALIFY;
                        if (tick) begin
                            cnt_d = cnt_inc[GF_IVL_W-1:0];
                        end
                    end
                end
                LN_QUALIFY: begin
                    if (sync_q == out_q) begin
                        state_d = LN_HOLD;
                        cnt_d   = '0;
                    end else if (tick && reach) begin
                        state_d = LN_HOLD;
                        out_d   = sync_q;
                        cnt_d   = '0;
                    end else if (tick) begin
                        cnt_d = cnt_inc[GF_IVL_W-1:0];
                    end
                end
                default: begin
                    state_d = LN_HOLD;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    assign line_out = out_q;

    // R2
    bypass_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byp |=> (line_out == $past(sync_q)))
        else $error("unfiltered line did not follow its synchronized input");

    // R5
    hold_between_ticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!byp && !tick) |=> $stable(line_out))
        else $error("filtered line changed away from a tick");

    // R6
    bounce_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!byp && state_q == LN_QUALIFY && sync_q == line_out) |=> (state_q == LN_HOLD && cnt_q == '0))
        else $error("bounce did not restart the qualification count");
endmodule

// File: rtl/gf_bank.sv
module gf_bank
    import gf_pkg::*;
#(
    parameter int unsigned NUM_PORTS = 4,
    parameter int unsigned CLK_HZ    = 250_000_000,
    parameter int unsigned TICK_NS   = 200
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [7:0]                     wr_addr,
    input  logic [7:0]                     wr_data,
    input  logic [NUM_PORTS*GF_PORT_W-1:0] raw_in,
    output logic [NUM_PORTS*GF_PORT_W-1:0] lines_out
);
    localparam int unsigned     NUM_LINES    = NUM_PORTS * GF_PORT_W;
    localparam longint unsigned TICK_PROD    = longint'(CLK_HZ) * longint'(TICK_NS);
    localparam int unsigned     TICK_CYC_RAW = int'(TICK_PROD / 64'd1_000_000_000);
    localparam int unsigned     TICK_CYC     = (TICK_CYC_RAW == 0) ? 1 : TICK_CYC_RAW;

    logic                 tick;
    logic [GF_IVL_W-1:0]  ivl;
    logic [NUM_LINES-1:0] en;

    gf_tick_gen #(
        .TICK_CYC (TICK_CYC)
    ) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    gf_cfg_regs #(
        .NUM_PORTS (NUM_PORTS)
    ) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .ivl     (ivl),
        .en      (en)
    );

    genvar i;
    generate
        for (i = 0; i < NUM_LINES; i++) begin : g_line
            gf_line u_line (
                .clk      (clk),
                .rst_n    (rst_n),
                .raw      (raw_in[i]),
                .en       (en[i]),
                .ivl      (ivl),
                .tick     (tick),
                .line_out (lines_out[i])
            );
        end
    endgenerate
endmodule

// File: tb/tb_gf_bank.sv
module tb_gf_bank;
    localparam int NP   = 4;
    localparam int NL   = NP * 8;
    localparam int TICK = 50;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [7:0]    wr_addr = '0;
    logic [7:0]    wr_data = '0;
    logic [NL-1:0] raw_in = '0;
    logic [NL-1:0] lines_out;

    int    checks = 0;
    int    errors = 0;
    bit    done = 0;
    string req = "R1";

    always #2 clk = ~clk;

    gf_bank #(.NUM_PORTS(NP), .CLK_HZ(250_000_000), .TICK_NS(200)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .raw_in(raw_in), .lines_out(lines_out)
    );

    // behavioural reference
    logic [NL-1:0] m_s1, m_s2, m_out;
    int            m_cnt [NL];
    int            m_ivl;
    logic [7:0]    m_en [NP];
    int            m_pc;

    always @(posedge clk or negedge rst_n) begin
        bit tk;
        bit byp;
        if (!rst_n) begin
            m_s1 = '0; m_s2 = '0; m_out = '0; m_ivl = 0; m_pc = 0;
            for (int i = 0; i < NL; i++) m_cnt[i] = 0;
            for (int p = 0; p < NP; p++) m_en[p] = 8'h00;
        end else begin
            tk = (m_pc == TICK - 1);
            for (int i = 0; i < NL; i++) begin
                byp = !m_en[i / 8][i % 8] || (m_ivl == 0);
                if (byp) begin
                    m_out[i] = m_s2[i]; m_cnt[i] = 0;
                end else if (m_s2[i] == m_out[i]) begin
                    m_cnt[i] = 0;
                end else if (tk) begin
                    if (m_cnt[i] + 1 >= m_ivl) begin
                        m_out[i] = m_s2[i]; m_cnt[i] = 0;
                    end else begin
                        m_cnt[i] = m_cnt[i] + 1;
                    end
                end
            end
            m_s2 = m_s1;
            m_s1 = raw_in;
            if (wr_en) begin
                if (wr_addr == 8'h08) m_ivl = (m_ivl & 32'hFFF00) | int'(wr_data);
                if (wr_addr == 8'h09) m_ivl = (m_ivl & 32'hF00FF) | (int'(wr_data) << 8);
                if (wr_addr == 8'h0A) begin
                    if (wr_data > 8'h0F) m_ivl = 32'hFFFFF;
                    else m_ivl = (m_ivl & 32'h0FFFF) | (int'(wr_data) << 16);
                end
                for (int p = 0; p < NP; p++)
                    if (int'(wr_addr) == 32'h44 + 16 * p) m_en[p] = wr_data;
            end
            m_pc = tk ? 0 : m_pc + 1;
        end
    end

    // every-cycle comparison
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (lines_out !== m_out) begin
                errors++;
                $display("FAIL %s cycle compare: actual %h expected %h", req, lines_out, m_out);
            end
        end
    end

    task automatic check(input string r, input logic [NL-1:0] act, input logic [NL-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", r, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    endtask

    initial begin
        logic [NL-1:0] held;
        logic [NL-1:0] mask;
        int            gap;
        @(negedge clk);
        cyc(4);
        rst_n = 1'b1;
        cyc(2);
        check("R1 reset outputs", lines_out, '0);

        // R2: nothing enabled, fast random input
        req = "R2";
        for (int k = 0; k < 60; k++) begin raw_in = $urandom; cyc(1); end
        raw_in = 32'hA5C3_0F96; cyc(4);
        check("R2 settled passthrough", lines_out, 32'hA5C3_0F96);

        // R3: all enabled, interval still 0
        req = "R3";
        for (int p = 0; p < NP; p++) wr(8'(8'h44 + 16 * p), 8'hFF);
        for (int k = 0; k < 60; k++) begin raw_in = $urandom; cyc(1); end
        raw_in = 32'h1234_5678; cyc(4);
        check("R3 interval zero passthrough", lines_out, 32'h1234_5678);

        // R5: interval of 3 ticks
        req = "R5";
        wr(8'h08, 8'h03);
        held = lines_out;
        raw_in = ~held; cyc(100);
        check("R5 unchanged before three ticks", lines_out, held);
        cyc(100);
        check("R5 changed after three ticks", lines_out, ~held);
        for (int k = 0; k < 5; k++) begin raw_in = $urandom; cyc(200); end
        check("R5 settled value", lines_out, raw_in);

        // R6: bounces shorter than the interval
        req = "R6";
        held = lines_out;
        for (int k = 0; k < 8; k++) begin
            raw_in = ~held; cyc(90);
            raw_in = held;  cyc(20);
        end
        check("R6 bounces absorbed", lines_out, held);

        // R8: per-bit enable and ignored addresses
        req = "R8";
        wr(8'h44, 8'h0F); wr(8'h54, 8'h00); wr(8'h64, 8'hF0); wr(8'h74, 8'h00);
        wr(8'h45, 8'hFF); wr(8'h10, 8'hAA); wr(8'h0B, 8'h77);
        mask = 32'hFF0F_FFF0;
        for (int k = 0; k < 100; k++) begin raw_in = $urandom; cyc(1); end
        held = lines_out;
        raw_in = ~raw_in; cyc(4);
        check("R8 disabled lines pass", lines_out & mask, raw_in & mask);
        check("R8 enabled lines hold", lines_out & ~mask, held & ~mask);
        cyc(200);

        // R9: live changes of interval and enable
        req = "R9";
        for (int p = 0; p < NP; p++) wr(8'(8'h44 + 16 * p), 8'hFF);
        wr(8'h08, 8'h05);
        cyc(300);
        held = lines_out;
        raw_in = ~held; cyc(160);
        check("R9 not yet qualified at five", lines_out, held);
        wr(8'h08, 8'h02);
        cyc(60);
        check("R9 lowered interval completes", lines_out, ~held);
        held = lines_out;
        raw_in = ~held; cyc(30);
        wr(8'h64, 8'h00);
        cyc(2);
        check("R9 disable follows input", lines_out & 32'h00FF_0000, raw_in & 32'h00FF_0000);
        cyc(200);

        // R4: distance between tick-aligned changes, interval 1
        req = "R4";
        wr(8'h64, 8'hFF); wr(8'h08, 8'h01);
        cyc(100);
        held = lines_out;
        raw_in[0] = ~held[0];
        gap = 0;
        while (lines_out[0] == held[0] && gap < 500) begin cyc(1); gap++; end
        raw_in[0] = held[0];
        gap = 0;
        while (lines_out[0] != held[0] && gap < 500) begin cyc(1); gap++; end
        check("R4 one tick between changes", 32'(gap), 32'(TICK));

        // R7: saturation and byte-wise interval
        req = "R7";
        wr(8'h08, 8'h02);
        raw_in = 32'h0F0F_3C3C; cyc(200);
        held = lines_out;
        wr(8'h0A, 8'h3C);
        raw_in = ~raw_in; cyc(2000);
        check("R7 saturated interval holds", lines_out, held);
        wr(8'h0A, 8'h00);
        wr(8'h09, 8'h00);
        cyc(300);
        check("R7 low bytes still large", lines_out, held);
        wr(8'h08, 8'h01);
        cyc(120);
        check("R7 rewritten interval of one", lines_out, raw_in);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule